// File: doc/BRIEF.md
# Reorder Buffer with Register Alias Table

This block keeps the program order of an out-of-order pipeline. Each decoded instruction claims the next free slot of a circular queue and receives that slot's number as its tag. If the instruction writes a register, the alias table marks that register as pending and records the tag. Execution units then return results by tag in any order. A result stays inside its slot until every older instruction has retired, and only then is it copied into the architectural register file.

Operand lookup is done in two steps. The register file is read first. If the register is pending, the stored tag selects a slot. The slot either supplies the finished value or tells the consumer which tag to wait for. Because every new writer gets a fresh tag, two writes to the same register, or a write that follows a read of it, cannot disturb each other.

When the oldest slot is finished and carries an exception, nothing from that slot or any younger slot is retired. The whole queue is emptied, all alias entries become valid again, and the block issues a fetch redirect to a handler address chosen by the exception cause, together with the faulting instruction's PC.

Top module: `rob_rename`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, `commit_valid` and `redirect_valid` are 0, and every register looks up as ready with value 0.
- R2: Allocations receive tags 0, 1, 2 and so on, modulo DEPTH. When DEPTH slots are outstanding, `alloc_ready` is 0, and an `alloc_valid` pulse in that state allocates nothing and renames nothing.
- R3: A register whose newest writer has not completed looks up with `ready` 0 and `tag` equal to that writer's tag.
- R4: A completion writes its value into the tagged slot. Lookups of the renamed register then return that value with `ready` 1, even before the slot retires.
- R5: Only the oldest slot retires, and only once it has completed. Retirement happens in program order, at most one slot per cycle. `commit_valid`, `commit_reg` and `commit_value` describe the retiring slot during its retire cycle.
- R6: With two pending writers of one register, retiring the older one leaves the register mapped to the younger one's tag. The register becomes ready with the younger value only after that value is available.
- R7: If the oldest completed slot carries an exception, it does not retire. `redirect_valid` is 1 for one cycle, with `redirect_pc` = VEC_BASE + cause × VEC_STRIDE (defaults 0x0100 and 16) and `redirect_epc` = that slot's PC. On the next cycle the queue is empty, the next tag is the faulting slot's tag, every register looks up as its last retired value, and later completions to flushed tags are ignored.
- R8: An instruction without a destination retires without writing any register and without changing any register's mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decode presents an instruction |
| alloc_has_dest | input | 1 | Instruction writes a register |
| alloc_dest | input | RW | Destination register |
| alloc_pc | input | AW | Instruction PC |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_tag | output | TW | Tag the next allocation receives |
| rs1_reg | input | RW | First lookup register |
| rs1_ready | output | 1 | First lookup value available |
| rs1_value | output | DW | First lookup value |
| rs1_tag | output | TW | Producer tag when not ready |
| rs2_reg | input | RW | Second lookup register |
| rs2_ready | output | 1 | Second lookup value available |
| rs2_value | output | DW | Second lookup value |
| rs2_tag | output | TW | Producer tag when not ready |
| cmpl_valid | input | 1 | An execution unit returns a result |
| cmpl_tag | input | TW | Slot the result belongs to |
| cmpl_value | input | DW | Result value |
| cmpl_exc | input | 1 | Result raised an exception |
| cmpl_cause | input | CW | Exception cause |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_has_dest | output | 1 | Retiring slot writes a register |
| commit_reg | output | RW | Register being written |
| commit_value | output | DW | Value being written |
| redirect_valid | output | 1 | Exception flush this cycle |
| redirect_pc | output | AW | Handler address |
| redirect_epc | output | AW | PC of the faulting instruction |

## Verification
The bound checker keeps its own occupancy count. On every cycle it checks that the count never exceeds DEPTH, that `alloc_ready` tracks free space, that tags advance by exactly one per allocation and hold otherwise, that retirement and flush never coincide, and that a flush leaves the queue empty on the next cycle. Value-level behaviour can only be shown by the bench's scenarios: out-of-order completion held back behind an incomplete head, lookups returning slot values before retirement, WAW mappings surviving the older writer's retirement, instructions without a destination leaving mappings alone, and the handler address, saved PC and precise register state after an exception.

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NREG = 8,
  parameter int DEPTH = 8,
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int CW = 3,
  parameter logic [AW-1:0] VEC_BASE = 16'h0100,
  parameter int VEC_STRIDE = 16,
  localparam int RW = $clog2(NREG),
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic          alloc_has_dest,
  input  logic [RW-1:0] alloc_dest,
  input  logic [AW-1:0] alloc_pc,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic [RW-1:0] rs1_reg,
  output logic          rs1_ready,
  output logic [DW-1:0] rs1_value,
  output logic [TW-1:0] rs1_tag,
  input  logic [RW-1:0] rs2_reg,
  output logic          rs2_ready,
  output logic [DW-1:0] rs2_value,
  output logic [TW-1:0] rs2_tag,
  input  logic          cmpl_valid,
  input  logic [TW-1:0] cmpl_tag,
  input  logic [DW-1:0] cmpl_value,
  input  logic          cmpl_exc,
  input  logic [CW-1:0] cmpl_cause,
  output logic          commit_valid,
  output logic          commit_has_dest,
  output logic [RW-1:0] commit_reg,
  output logic [DW-1:0] commit_value,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] redirect_epc
);
  localparam int PW = TW + 1;
  localparam logic [PW-1:0] STEP = PW'(1);

  logic [PW-1:0] head, tail;
  logic [DEPTH-1:0] e_valid, e_done, e_exc, e_hasd;
  logic [RW-1:0] e_dest [DEPTH];
  logic [DW-1:0] e_value [DEPTH];
  logic [AW-1:0] e_pc [DEPTH];
  logic [CW-1:0] e_cause [DEPTH];

  logic [DW-1:0] rf [NREG];
  logic [NREG-1:0] map_ok;
  logic [TW-1:0] map_tag [NREG];

  logic [TW-1:0] hd, tl;
  logic head_done, flush, retire, full, alloc_go;

  assign hd = head[TW-1:0];
  assign tl = tail[TW-1:0];
  assign head_done = e_valid[hd] && e_done[hd];
  assign flush = head_done && e_exc[hd];
  assign retire = head_done && !e_exc[hd];
  assign full = (hd == tl) && (head[TW] != tail[TW]);
  assign alloc_ready = !full && !flush;
  assign alloc_go = alloc_valid && alloc_ready;
  assign alloc_tag = tl;

  assign commit_valid = retire;
  assign commit_has_dest = e_hasd[hd];
  assign commit_reg = e_dest[hd];
  assign commit_value = e_value[hd];

  assign redirect_valid = flush;
  assign redirect_pc = VEC_BASE + AW'(e_cause[hd]) * AW'(VEC_STRIDE);
  assign redirect_epc = e_pc[hd];

  function automatic logic [DW:0] look(input logic [RW-1:0] r);
    if (map_ok[r]) look = {1'b1, rf[r]};
    else look = {e_done[map_tag[r]], e_value[map_tag[r]]};
  endfunction

  assign {rs1_ready, rs1_value} = look(rs1_reg);
  assign {rs2_ready, rs2_value} = look(rs2_reg);
  assign rs1_tag = map_tag[rs1_reg];
  assign rs2_tag = map_tag[rs2_reg];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      e_valid <= '0;
      e_done <= '0;
      e_exc <= '0;
      e_hasd <= '0;
      map_ok <= '1;
      for (int i = 0; i < DEPTH; i++) begin
        e_dest[i] <= '0;
        e_value[i] <= '0;
        e_pc[i] <= '0;
        e_cause[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) begin
        rf[r] <= '0;
        map_tag[r] <= '0;
      end
    end else if (flush) begin
      e_valid <= '0;
      e_done <= '0;
      map_ok <= '1;
      tail <= head;
    end else begin
      if (retire) begin
        e_valid[hd] <= 1'b0;
        head <= head + STEP;
        if (e_hasd[hd]) begin
          rf[e_dest[hd]] <= e_value[hd];
          if (!map_ok[e_dest[hd]] && map_tag[e_dest[hd]] == hd)
            map_ok[e_dest[hd]] <= 1'b1;
        end
      end
      if (cmpl_valid && e_valid[cmpl_tag] && !e_done[cmpl_tag]) begin
        e_done[cmpl_tag] <= 1'b1;
        e_value[cmpl_tag] <= cmpl_value;
        e_exc[cmpl_tag] <= cmpl_exc;
        e_cause[cmpl_tag] <= cmpl_cause;
      end
      if (alloc_go) begin
        e_valid[tl] <= 1'b1;
        e_done[tl] <= 1'b0;
        e_exc[tl] <= 1'b0;
        e_hasd[tl] <= alloc_has_dest;
        e_dest[tl] <= alloc_dest;
        e_pc[tl] <= alloc_pc;
        tail <= tail + STEP;
        if (alloc_has_dest) begin
          map_ok[alloc_dest] <= 1'b0;
          map_tag[alloc_dest] <= tl;
        end
      end
    end
  end
endmodule

module rob_rename_chk #(
  parameter int DEPTH = 8,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [TW-1:0] alloc_tag,
  input logic          commit_valid,
  input logic          redirect_valid
);
  logic [TW+1:0] occ;
  logic fire;
  assign fire = alloc_valid && alloc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (redirect_valid) occ <= '0;
    else occ <= occ + (TW+2)'(fire) - (TW+2)'(commit_valid);
  end

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (TW+2)'(DEPTH));
  assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (TW+2)'(DEPTH)) |-> !alloc_ready);
  assert_space_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < (TW+2)'(DEPTH) && !redirect_valid) |-> alloc_ready);
  assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> alloc_tag == $past(alloc_tag) + TW'(1));
  assert_tag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !redirect_valid) |=> $stable(alloc_tag));
  assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (!commit_valid && !redirect_valid));
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && redirect_valid));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (!commit_valid && !redirect_valid && alloc_ready));
endmodule

bind rob_rename rob_rename_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .commit_valid(commit_valid), .redirect_valid(redirect_valid)
);

// File: tb/rob_rename_tb.sv
module rob_rename_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, alloc_valid, alloc_has_dest, alloc_ready;
  logic [2:0] alloc_dest, alloc_tag, rs1_reg, rs1_tag, rs2_reg, rs2_tag, cmpl_tag, cmpl_cause, commit_reg;
  logic [15:0] alloc_pc, rs1_value, rs2_value, cmpl_value, commit_value, redirect_pc, redirect_epc;
  logic rs1_ready, rs2_ready, cmpl_valid, cmpl_exc, commit_valid, commit_has_dest, redirect_valid;

  rob_rename u_dut (.*);

  typedef struct { logic hasd; logic [2:0] r; logic [15:0] v; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  logic mon_on = 0, redir_exp = 0, done = 0;
  logic [15:0] redir_pc_exp, redir_epc_exp;

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (mon_on && commit_valid) begin
      if (q.size() == 0) chk(0, "R5", "unexpected commit of reg", 32'(commit_reg), 0);
      else begin
        e = q.pop_front();
        chk(commit_has_dest == e.hasd, "R8", "commit_has_dest", 32'(commit_has_dest), 32'(e.hasd));
        if (e.hasd) begin
          chk(commit_reg == e.r, "R5", "commit_reg", 32'(commit_reg), 32'(e.r));
          chk(commit_value == e.v, "R5", "commit_value", 32'(commit_value), 32'(e.v));
        end
      end
    end
    if (mon_on && redirect_valid) begin
      chk(redir_exp, "R7", "unexpected redirect", 1, 0);
      if (redir_exp) begin
        chk(redirect_pc == redir_pc_exp, "R7", "redirect_pc", 32'(redirect_pc), 32'(redir_pc_exp));
        chk(redirect_epc == redir_epc_exp, "R7", "redirect_epc", 32'(redirect_epc), 32'(redir_epc_exp));
      end
      redir_exp = 0;
    end
  end

  task automatic alloc(input logic hasd, input logic [2:0] d, input logic [15:0] pc,
                       input logic [15:0] v, input bit commits, output logic [2:0] tag);
    alloc_valid = 1; alloc_has_dest = hasd; alloc_dest = d; alloc_pc = pc;
    @(negedge clk);
    chk(alloc_ready == 1, "R2", "alloc_ready", 32'(alloc_ready), 1);
    tag = alloc_tag;
    if (commits) q.push_back('{hasd, d, v});
    @(posedge clk); #1 alloc_valid = 0;
  endtask

  task automatic complete(input logic [2:0] t, input logic [15:0] v, input logic exc, input logic [2:0] cause);
    cmpl_valid = 1; cmpl_tag = t; cmpl_value = v; cmpl_exc = exc; cmpl_cause = cause;
    @(posedge clk); #1 cmpl_valid = 0;
  endtask

  task automatic look(input logic [2:0] r, input bit rdy, input logic [15:0] v, input logic [2:0] t, input string req);
    rs1_reg = r; rs2_reg = r;
    @(negedge clk);
    chk(rs1_ready == rdy && rs2_ready == rdy, req, "lookup ready", 32'(rs1_ready), 32'(rdy));
    if (rdy) chk(rs1_value == v && rs2_value == v, req, "lookup value", 32'(rs1_value), 32'(v));
    else chk(rs1_tag == t && rs2_tag == t, req, "lookup tag", 32'(rs1_tag), 32'(t));
    @(posedge clk); #1;
  endtask

  task automatic no_commit(input string req);
    @(negedge clk);
    chk(commit_valid == 0, req, "commit_valid while head incomplete", 32'(commit_valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [15:0] fill_val(input int k);
    if (k == 0) return 16'h0444;
    if (k == 1) return 16'h0000;
    return 16'h3000 + 16'(k);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] t;
    rst_n = 0; alloc_valid = 0; alloc_has_dest = 0; alloc_dest = 0; alloc_pc = 0;
    rs1_reg = 0; rs2_reg = 0; cmpl_valid = 0; cmpl_tag = 0; cmpl_value = 0; cmpl_exc = 0; cmpl_cause = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; mon_on = 1;

    @(negedge clk);
    chk(alloc_ready == 1, "R1", "alloc_ready", 32'(alloc_ready), 1);
    chk(alloc_tag == 0, "R1", "alloc_tag", 32'(alloc_tag), 0);
    chk(commit_valid == 0 && redirect_valid == 0, "R1", "commit/redirect", 32'({commit_valid, redirect_valid}), 0);
    @(posedge clk); #1;
    look(3, 1, 0, 0, "R1");

    alloc(1, 1, 16'h10, 16'h0111, 1, t); chk(t == 0, "R2", "tag A", 32'(t), 0);
    alloc(1, 2, 16'h14, 16'h0222, 1, t); chk(t == 1, "R2", "tag B", 32'(t), 1);
    alloc(1, 1, 16'h18, 16'h0333, 1, t); chk(t == 2, "R2", "tag C", 32'(t), 2);
    look(1, 0, 0, 2, "R3");
    look(2, 0, 0, 1, "R3");
    complete(1, 16'h0222, 0, 0);
    no_commit("R5");
    look(2, 1, 16'h0222, 0, "R4");
    complete(0, 16'h0111, 0, 0);
    idle(3);
    look(1, 0, 0, 2, "R6");
    look(2, 1, 16'h0222, 0, "R5");
    complete(2, 16'h0333, 0, 0);
    idle(2);
    look(1, 1, 16'h0333, 0, "R6");
    chk(q.size() == 0, "R5", "pending commits", 32'(q.size()), 0);

    for (int k = 0; k < 8; k++) begin
      if (k == 0) alloc(1, 4, 16'h20, fill_val(k), 1, t);
      else if (k == 1) alloc(0, 4, 16'h24, fill_val(k), 1, t);
      else alloc(1, 3, 16'h20 + 16'(4 * k), fill_val(k), 1, t);
      chk(t == 3'(k + 3), "R2", "wrap tag", 32'(t), 32'(3'(k + 3)));
    end
    @(negedge clk);
    chk(alloc_ready == 0, "R2", "alloc_ready when full", 32'(alloc_ready), 0);
    @(posedge clk); #1;
    alloc_valid = 1; alloc_has_dest = 1; alloc_dest = 7; alloc_pc = 16'h99;
    @(posedge clk); #1 alloc_valid = 0;
    look(7, 1, 0, 0, "R2");
    look(4, 0, 0, 3, "R8");
    for (int k = 7; k >= 0; k--) complete(3'(k + 3), fill_val(k), 0, 0);
    idle(10);
    look(4, 1, 16'h0444, 0, "R8");
    look(3, 1, 16'h3007, 0, "R6");
    chk(q.size() == 0, "R5", "pending commits after fill", 32'(q.size()), 0);

    alloc(1, 5, 16'h40, 16'h0555, 1, t); chk(t == 3, "R2", "tag after ignored alloc", 32'(t), 3);
    alloc(1, 6, 16'h44, 16'h0666, 0, t); chk(t == 4, "R2", "tag E", 32'(t), 4);
    alloc(1, 5, 16'h48, 16'h0999, 0, t); chk(t == 5, "R2", "tag F", 32'(t), 5);
    complete(3, 16'h0555, 0, 0);
    complete(5, 16'h0999, 0, 0);
    redir_pc_exp = 16'h0130; redir_epc_exp = 16'h44; redir_exp = 1;
    complete(4, 16'h0666, 1, 3);
    idle(2);
    chk(redir_exp == 0, "R7", "redirect seen", 32'(redir_exp), 0);
    look(5, 1, 16'h0555, 0, "R7");
    look(6, 1, 16'h0000, 0, "R7");
    @(negedge clk);
    chk(alloc_ready == 1, "R7", "alloc_ready after flush", 32'(alloc_ready), 1);
    @(posedge clk); #1;
    complete(5, 16'h0777, 0, 0);
    no_commit("R7");
    alloc(1, 7, 16'h50, 16'h0777, 1, t); chk(t == 4, "R7", "tag after flush", 32'(t), 4);
    complete(4, 16'h0777, 0, 0);
    idle(3);
    look(7, 1, 16'h0777, 0, "R7");
    chk(q.size() == 0, "R7", "pending commits at end", 32'(q.size()), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule